// File: doc/BRIEF.md
# Per-thread interrupt management register window

This block keeps the interrupt presentation state of one processor thread and exposes it through a byte-addressed, big-endian load/store window. The window is the operating-system privilege view. The register space holds four 16-byte privilege rings: user at 0x00, OS at 0x10, hypervisor pool at 0x20 and hypervisor physical at 0x30. Only the OS ring can be reached through ordinary accesses. Inside that ring, software can change only the current-priority byte. Every other byte is either constant zero or driven by the presentation logic.

The interrupt routing side posts a pending priority on a side input. The block folds that priority into a pending-priority buffer and derives the most favoured pending priority from it. When that priority beats the current priority, the block raises an exception flag and its interrupt line to the processor. A two-byte load at a fixed special address acknowledges the interrupt. It returns the flag byte and the current priority, and moves the current priority up to the priority that was pending.

Top module: `thread_irq_window`

## Requirements
- R1: Synchronous reset clears every stored byte, drops `irq_out` and `rd_valid`. Because the pending buffer is empty after reset, the derived pending-priority byte (OS ring offset 7) reads 0xFF.
- R2: An ordinary access (address below 0x800) whose address bits [10:4] are not 0x01 is rejected. A rejected load returns all 64 bits set. A rejected store changes nothing.
- R3: A load of N bytes (N = 1 to 8) completes one cycle after it is presented, with `rd_valid` high. The byte at the lowest address lands in the most significant of the N low-order byte lanes of `rd_data`, and the upper bytes are zero.
- R4: A 1-byte store to address 0x011 sets the current priority (CPPR, OS ring offset 1). A value above 7 is stored as 0xFF. A 1-byte store to any other address has no effect.
- R5: A 4- or 8-byte store takes only the byte that falls on address 0x011, unclamped, as the new CPPR. Every other covered byte is left unchanged. Stores of any other size are dropped.
- R6: `post_prio` = p with `post_valid` sets bit (7-p) of the pending buffer (IPB, OS ring offset 2). The pending priority (PIPR, offset 7) is the lowest p whose bit is set, or 0xFF when the buffer is empty.
- R7: The exception flag is bit 7 of the OS notification byte (offset 0). The flag and `irq_out` are high exactly when PIPR is numerically below CPPR. Both are updated on the same clock edge that changes CPPR or IPB.
- R8: A 2-byte load at 0x810 returns the notification byte in bits [15:8] and CPPR in bits [7:0], as they were before the load. On the same edge it sets CPPR to PIPR, clears that priority's IPB bit, and so drops the flag and `irq_out`.
- R9: Addresses at or above 0x800 never reach the registers. Every load there other than the 2-byte acknowledge returns all ones and has no side effect, and every store there is ignored.
- R10: A post and an acknowledge in the same cycle both take effect: IPB becomes (IPB without the acknowledged bit) with the posted bit added. The flag then reflects the new PIPR against the new CPPR.
- R11: Address bit 11 alone selects the special range, so the ring check applies only below 0x800. An ordinary address with bits [10:8] non-zero counts as outside the OS ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 12 | Byte address within the window |
| acc_size | input | 4 | Access size in bytes (1 to 8) |
| acc_wdata | input | 64 | Store data, right-justified, big-endian |
| post_valid | input | 1 | Post a pending priority this cycle |
| post_prio | input | 3 | Priority being posted (0 most favoured) |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 64 | Load result, right-justified |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Two pairs of operations can fall in the same cycle. The first pair is an acknowledge with a post from the routing side. The second is a current-priority store with a post. The bench drives each pair on one edge. It picks the posted priority so that the outcome differs from either operation alone: after an acknowledge paired with a more favoured post, the interrupt line must stay high. It then judges the pair by the line level on the next sample and by a readback of the OS ring bytes.

// File: rtl/twin_pkg.sv
package twin_pkg;

    localparam int LANES      = 8;
    localparam int DATA_W     = LANES * 8;
    localparam int SIZE_W     = $clog2(LANES) + 1;
    localparam int LANE_SW    = $clog2(LANES);
    localparam int ADDR_W     = 12;
    localparam int RING_BYTES = 16;
    localparam int RINGS      = 4;
    localparam int IMG_BYTES  = RINGS * RING_BYTES;
    localparam int IMG_AW     = $clog2(IMG_BYTES);
    localparam int RING_AW    = $clog2(RING_BYTES);
    localparam int RF_W       = ADDR_W - 1 - RING_AW;
    localparam int PRIO_W     = 3;
    localparam int PEND_W     = 1 << PRIO_W;

    localparam logic [7:0] PRIO_TOP  = 8'(PEND_W - 1);
    localparam logic [7:0] PRIO_NONE = 8'hFF;

    localparam int OS_RING  = 1;
    localparam int OFS_NSR  = 0;
    localparam int OFS_CPPR = 1;
    localparam int OFS_IPB  = 2;
    localparam int OFS_PIPR = 7;
    localparam int NSR_EXC_BIT = 7;

    localparam logic [ADDR_W-1:0] CPPR_ADDR = ADDR_W'(OS_RING * RING_BYTES + OFS_CPPR);
    localparam logic [ADDR_W-1:0] ACK_ADDR  = 12'h810;
    localparam logic [SIZE_W-1:0] ACK_SIZE  = SIZE_W'(2);

    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_REG_RD,
        OP_REG_WR,
        OP_ACK,
        OP_ONES_RD,
        OP_DROP
    } op_e;

    typedef struct packed {
        byte_t nsr;
        byte_t cppr;
        byte_t ipb;
        byte_t pipr;
    } os_view_t;

    function automatic byte_t prio_clamp(byte_t v);
        return (v > PRIO_TOP) ? PRIO_NONE : v;
    endfunction

    function automatic byte_t prio_onehot(logic [PRIO_W-1:0] p);
        return byte_t'(1 << (PEND_W - 1 - int'(p)));
    endfunction

    function automatic byte_t prio_to_mask(byte_t p);
        return (p <= PRIO_TOP) ? prio_onehot(p[PRIO_W-1:0]) : 8'h00;
    endfunction

    function automatic byte_t first_pending(byte_t ipb);
        byte_t r;
        r = PRIO_NONE;
        for (int k = PEND_W - 1; k >= 0; k--) begin
            if (ipb[PEND_W-1-k]) r = byte_t'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/twin_decode.sv
module twin_decode
    import twin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SIZE_W-1:0] acc_size,
    output op_e               op
);

    logic special;
    logic in_os;
    logic size_rd_ok;
    logic size_wr_ok;

    assign special    = acc_addr[ADDR_W-1];
    assign in_os      = acc_addr[ADDR_W-2:RING_AW] == RF_W'(OS_RING);
    assign size_rd_ok = (acc_size != '0) && (acc_size <= SIZE_W'(LANES));
    assign size_wr_ok = (acc_size == SIZE_W'(1)) || (acc_size == SIZE_W'(4))
                     || (acc_size == SIZE_W'(LANES));

    always_comb begin
        op = OP_IDLE;
        if (acc_valid) begin
            if (special) begin
                if (acc_write)
                    op = OP_DROP;
                else if (acc_addr == ACK_ADDR && acc_size == ACK_SIZE)
                    op = OP_ACK;
                else
                    op = OP_ONES_RD;
            end else if (!in_os) begin
                op = acc_write ? OP_DROP : OP_ONES_RD;
            end else if (acc_write) begin
                op = size_wr_ok ? OP_REG_WR : OP_DROP;
            end else begin
                op = size_rd_ok ? OP_REG_RD : OP_ONES_RD;
            end
        end
    end

    // R11
    special_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && special) |-> (op != OP_REG_RD && op != OP_REG_WR));

endmodule

// File: rtl/twin_store_lane.sv
module twin_store_lane
    import twin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              cppr_we,
    output byte_t             cppr_val
);

    logic [LANES-1:0] lane_hit;
    byte_t            lane_val [LANES];
    byte_t            raw;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_SW-1:0] lane_sh;
        assign lane_sh     = LANE_SW'(acc_size - SIZE_W'(1) - SIZE_W'(i));
        assign lane_hit[i] = (SIZE_W'(i) < acc_size)
                          && ((acc_addr + ADDR_W'(i)) == CPPR_ADDR);
        assign lane_val[i] = byte_t'(acc_wdata >> {lane_sh, 3'b000});
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_hit[i]) raw = raw | lane_val[i];
        end
    end

    assign cppr_we  = (op == OP_REG_WR) && (|lane_hit);
    assign cppr_val = (acc_size == SIZE_W'(1)) ? prio_clamp(raw) : raw;

    // R4
    clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cppr_we && acc_size == SIZE_W'(1)) |-> (cppr_val <= PRIO_TOP || cppr_val == PRIO_NONE));

endmodule

// File: rtl/twin_presenter.sv
module twin_presenter
    import twin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cppr_we,
    input  byte_t             cppr_val,
    input  logic              ack,
    input  logic              post_valid,
    input  logic [PRIO_W-1:0] post_prio,
    output os_view_t          view,
    output logic              irq_out
);

    byte_t cppr_q, ipb_q, nsr_q;
    byte_t pipr;
    byte_t ack_mask, post_mask;
    byte_t ipb_n, cppr_n, pipr_n;
    logic  excp_n;

    assign pipr = first_pending(ipb_q);

    always_comb begin
        ack_mask  = ack ? prio_to_mask(pipr) : 8'h00;
        post_mask = post_valid ? prio_onehot(post_prio) : 8'h00;
        ipb_n     = (ipb_q & ~ack_mask) | post_mask;
        if (ack)
            cppr_n = pipr;
        else if (cppr_we)
            cppr_n = cppr_val;
        else
            cppr_n = cppr_q;
        pipr_n = first_pending(ipb_n);
        excp_n = pipr_n < cppr_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cppr_q <= '0;
            ipb_q  <= '0;
            nsr_q  <= '0;
        end else begin
            cppr_q <= cppr_n;
            ipb_q  <= ipb_n;
            nsr_q  <= excp_n ? byte_t'(1 << NSR_EXC_BIT) : 8'h00;
        end
    end

    assign view    = '{nsr: nsr_q, cppr: cppr_q, ipb: ipb_q, pipr: pipr};
    assign irq_out = nsr_q[NSR_EXC_BIT];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cppr_q == 8'h00 && ipb_q == 8'h00 && !irq_out));

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out == (pipr < cppr_q));

    // R8
    ack_cppr_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> cppr_q == $past(pipr));

    // R8
    ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !post_valid) |=> !irq_out);

    // R10
    post_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        post_valid |=> (ipb_q & prio_onehot($past(post_prio))) != 8'h00);

endmodule

// File: rtl/twin_readback.sv
module twin_readback
    import twin_pkg::*;
(
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SIZE_W-1:0] acc_size,
    input  os_view_t          view,
    output logic [DATA_W-1:0] rd_word
);

    localparam int OS_BASE = OS_RING * RING_BYTES;

    function automatic byte_t byte_at(logic [IMG_AW-1:0] idx, os_view_t v);
        byte_t b;
        b = 8'h00;
        if (idx == IMG_AW'(OS_BASE + OFS_NSR))  b = v.nsr;
        if (idx == IMG_AW'(OS_BASE + OFS_CPPR)) b = v.cppr;
        if (idx == IMG_AW'(OS_BASE + OFS_IPB))  b = v.ipb;
        if (idx == IMG_AW'(OS_BASE + OFS_PIPR)) b = v.pipr;
        return b;
    endfunction

    logic [DATA_W-1:0] lane_word [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [IMG_AW-1:0]  lane_idx;
        logic [LANE_SW-1:0] lane_pos;
        byte_t              lane_byte;
        assign lane_idx     = acc_addr[IMG_AW-1:0] + IMG_AW'(i);
        assign lane_pos     = LANE_SW'(acc_size - SIZE_W'(1) - SIZE_W'(i));
        assign lane_byte    = byte_at(lane_idx, view);
        assign lane_word[i] = (SIZE_W'(i) < acc_size)
                            ? (DATA_W'(lane_byte) << {lane_pos, 3'b000}) : '0;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < LANES; i++) rd_word = rd_word | lane_word[i];
    end

endmodule

// File: rtl/thread_irq_window.sv
module thread_irq_window
    import twin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              post_valid,
    input  logic [PRIO_W-1:0] post_prio,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_out
);

    op_e               op;
    logic              cppr_we;
    byte_t             cppr_val;
    os_view_t          view;
    logic [DATA_W-1:0] rd_word;
    logic              ack;

    twin_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .op        (op)
    );

    twin_store_lane u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .acc_wdata (acc_wdata),
        .cppr_we   (cppr_we),
        .cppr_val  (cppr_val)
    );

    assign ack = (op == OP_ACK);

    twin_presenter u_present (
        .clk        (clk),
        .rst        (rst),
        .cppr_we    (cppr_we),
        .cppr_val   (cppr_val),
        .ack        (ack),
        .post_valid (post_valid),
        .post_prio  (post_prio),
        .view       (view),
        .irq_out    (irq_out)
    );

    twin_readback u_read (
        .acc_addr (acc_addr),
        .acc_size (acc_size),
        .view     (view),
        .rd_word  (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (op == OP_REG_RD) || (op == OP_ACK) || (op == OP_ONES_RD);
            case (op)
                OP_ONES_RD: rd_data <= '1;
                OP_ACK:     rd_data <= DATA_W'({view.nsr, view.cppr});
                OP_REG_RD:  rd_data <= rd_word;
                default:    rd_data <= rd_data;
            endcase
        end
    end

    // R2
    reject_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !acc_addr[ADDR_W-1]
         && acc_addr[ADDR_W-2:RING_AW] != RF_W'(OS_RING))
        |=> (rd_valid && rd_data == '1));

    // R9
    special_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr[ADDR_W-1]
         && !(acc_addr == ACK_ADDR && acc_size == ACK_SIZE))
        |=> (rd_valid && rd_data == '1));

    // R9
    special_write_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_addr[ADDR_W-1]) |=> $stable(view.cppr));

    // R3
    load_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> rd_valid);

endmodule

// File: tb/thread_irq_window_bench.sv
module thread_irq_window_bench;
    import twin_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [SIZE_W-1:0] acc_size = '0;
    logic [DATA_W-1:0] acc_wdata = '0;
    logic              post_valid = 1'b0;
    logic [PRIO_W-1:0] post_prio = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              irq_out;

    always #10 clk = ~clk;

    thread_irq_window u_thread_irq_window (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .acc_size   (acc_size),
        .acc_wdata  (acc_wdata),
        .post_valid (post_valid),
        .post_prio  (post_prio),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .irq_out    (irq_out)
    );

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [1:0]  kind;   // 0 load, 1 store, 2 post
        logic [3:0]  size;
        logic [11:0] addr;
        logic [63:0] wdata;
        logic [63:0] exp;
        logic        irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd8, 12'h010, 64'h0, 64'hFF, 1'b0, 4'd1},                   // R1 R3 empty ring
        '{2'd2, 4'd0, 12'h000, 64'h3, 64'h0, 1'b0, 4'd6},                    // R6 post prio 3
        '{2'd1, 4'd1, 12'h011, 64'h05, 64'h0, 1'b1, 4'd7},                   // R4 R7 cppr 5
        '{2'd0, 4'd4, 12'h010, 64'h0, 64'h80051000, 1'b1, 4'd3},             // R3 R7
        '{2'd0, 4'd1, 12'h017, 64'h0, 64'h03, 1'b1, 4'd6},                   // R6 pipr
        '{2'd1, 4'd1, 12'h011, 64'h09, 64'h0, 1'b1, 4'd4},                   // R4 clamp
        '{2'd0, 4'd2, 12'h010, 64'h0, 64'h80FF, 1'b1, 4'd4},                 // R4
        '{2'd1, 4'd1, 12'h012, 64'hAA, 64'h0, 1'b1, 4'd4},                   // R4 other byte
        '{2'd0, 4'd1, 12'h012, 64'h0, 64'h10, 1'b1, 4'd4},                   // R4
        '{2'd0, 4'd8, 12'h020, 64'h0, ONES, 1'b1, 4'd2},                     // R2 pool ring
        '{2'd1, 4'd8, 12'h00C, 64'h0000_0000_0001_0000, 64'h0, 1'b1, 4'd2},  // R2 store rejected
        '{2'd0, 4'd1, 12'h011, 64'h0, 64'hFF, 1'b1, 4'd2},                   // R2
        '{2'd1, 4'd4, 12'h010, 64'h11023344, 64'h0, 1'b0, 4'd5},             // R5 word store
        '{2'd0, 4'd4, 12'h010, 64'h0, 64'h00021000, 1'b0, 4'd5},             // R5
        '{2'd1, 4'd8, 12'h011, 64'h06AA_BBCC_DDEE_FF11, 64'h0, 1'b1, 4'd5},  // R5 dword store
        '{2'd1, 4'd2, 12'h011, 64'h0001, 64'h0, 1'b1, 4'd5},                 // R5 size 2 dropped
        '{2'd0, 4'd2, 12'h010, 64'h0, 64'h8006, 1'b1, 4'd5},                 // R5
        '{2'd0, 4'd2, 12'h810, 64'h0, 64'h8006, 1'b0, 4'd8},                 // R8 ack
        '{2'd0, 4'd4, 12'h010, 64'h0, 64'h00030000, 1'b0, 4'd8},             // R8
        '{2'd0, 4'd4, 12'h818, 64'h0, ONES, 1'b0, 4'd9},                     // R9
        '{2'd0, 4'd2, 12'h810, 64'h0, 64'h0003, 1'b0, 4'd8},                 // R8 empty ack
        '{2'd0, 4'd1, 12'h011, 64'h0, 64'hFF, 1'b0, 4'd8},                   // R8
        '{2'd1, 4'd1, 12'h812, 64'h05, 64'h0, 1'b0, 4'd9},                   // R9 special store
        '{2'd1, 4'd1, 12'h013, 64'h07, 64'h0, 1'b0, 4'd4},                   // R4
        '{2'd0, 4'd4, 12'h010, 64'h0, 64'h00FF0000, 1'b0, 4'd9},             // R9 R4
        '{2'd0, 4'd8, 12'h110, 64'h0, ONES, 1'b0, 4'd11},                    // R11
        '{2'd0, 4'd1, 12'h810, 64'h0, ONES, 1'b0, 4'd9},                     // R9 wrong size
        '{2'd0, 4'd2, 12'h010, 64'h0, 64'h00FF, 1'b0, 4'd9}                  // R9 no side effect
    };

    int  nchk = 0;
    int  nerr = 0;
    bit  done = 1'b0;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic drive(logic av, logic wr, logic [3:0] sz, logic [11:0] ad,
                         logic [63:0] wd, logic pv, logic [2:0] pp);
        acc_valid  = av;
        acc_write  = wr;
        acc_size   = sz;
        acc_addr   = ad;
        acc_wdata  = wd;
        post_valid = pv;
        post_prio  = pp;
        @(negedge clk);
        acc_valid  = 1'b0;
        acc_write  = 1'b0;
        post_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset irq_out", 64'(irq_out), 64'h0);
        check("R1 reset rd_valid", 64'(rd_valid), 64'h0);

        for (int n = 0; n < NV; n++) begin
            vec_t v;
            string tag;
            v = VECS[n];
            tag = $sformatf("R%0d step %0d", v.req, n);
            if (v.kind == 2'd2)
                drive(1'b0, 1'b0, 4'd0, 12'h0, 64'h0, 1'b1, v.wdata[2:0]);
            else
                drive(1'b1, v.kind == 2'd1, v.size, v.addr, v.wdata, 1'b0, 3'd0);
            if (v.kind == 2'd0) begin
                check({tag, " rd_valid"}, 64'(rd_valid), 64'h1);
                check({tag, " rd_data"}, rd_data, v.exp);
            end else begin
                check({tag, " rd_valid"}, 64'(rd_valid), 64'h0);
            end
            check({tag, " irq_out"}, 64'(irq_out), 64'(v.irq));
        end

        // R6 R7: post prio 1 against CPPR 0xFF
        drive(1'b0, 1'b0, 4'd0, 12'h0, 64'h0, 1'b1, 3'd1);
        check("R7 post raises irq", 64'(irq_out), 64'h1);
        drive(1'b1, 1'b1, 4'd1, 12'h011, 64'h04, 1'b0, 3'd0);
        check("R7 cppr 4 keeps irq", 64'(irq_out), 64'h1);
        // R10: acknowledge and a more favoured post on the same edge
        drive(1'b1, 1'b0, 4'd2, 12'h810, 64'h0, 1'b1, 3'd0);
        check("R10 ack+post data", rd_data, 64'h8004);
        check("R10 ack+post irq stays", 64'(irq_out), 64'h1);
        drive(1'b1, 1'b0, 4'd4, 12'h010, 64'h0, 1'b0, 3'd0);
        check("R10 ring after ack+post", rd_data, 64'h80018000);
        drive(1'b1, 1'b0, 4'd2, 12'h810, 64'h0, 1'b0, 3'd0);
        check("R8 second ack data", rd_data, 64'h8001);
        check("R8 second ack irq", 64'(irq_out), 64'h0);
        // R7: CPPR store and post on the same edge
        drive(1'b1, 1'b1, 4'd1, 12'h011, 64'h02, 1'b1, 3'd1);
        check("R7 cppr+post irq", 64'(irq_out), 64'h1);
        drive(1'b1, 1'b0, 4'd1, 12'h017, 64'h0, 1'b0, 3'd0);
        check("R6 pipr after cppr+post", rd_data, 64'h01);

        // R1: reset in the middle of activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset irq_out", 64'(irq_out), 64'h0);
        check("R1 mid reset rd_valid", 64'(rd_valid), 64'h0);
        drive(1'b1, 1'b0, 4'd8, 12'h010, 64'h0, 1'b0, 3'd0);
        check("R1 ring after reset", rd_data, 64'hFF);

        finish_run();
    end

endmodule